// File: doc/BRIEF.md
# Segmented Recirculating Delay-Line Memory

This block is a serial memory. Its contents exist only as bits travelling around a closed shift ring, which advances by one position on every clock. The ring is divided into equal segments, and each segment holds one short word. A free-running position counter is kept in step with the ring, so the block always knows which segment is currently at the single access point.

A client issues a write by giving a segment number and a word. The block waits until that segment reaches the access point. It then replaces every bit of the segment with the new word, so that old ones are cleared along with the rest, and returns a one-cycle acknowledge. A read waits for the selected segment in the same way. It picks the bits off one at a time as they pass, holds the word in a static register, and raises a valid flag. The valid flag stays up until the next read is accepted. Only one access runs at a time. While an access is pending, `busy` is high and new requests are not taken.

Top module: `seg_delay_mem`

## Requirements
- R1: A synchronous reset sets every ring bit, the position counter and `rd_data` to zero, and leaves `busy`, `wr_ack` and `rd_valid` low.
- R2: The position counter starts at 0 after reset and advances by one each clock, modulo L = SEG_W*SEG_N. Bit k of the word in segment s (bit 0 first, LSB of the word) is at the access point when the counter equals s*SEG_W+k.
- R3: A write request is accepted in an idle cycle in which the counter equals p. `wr_ack` is high for exactly one cycle, 1+d+SEG_W clock edges after the accepting edge, where d = (s*SEG_W - p - 1) mod L.
- R4: A write replaces every bit of the addressed segment, so writing 0000 over 1111 reads back as 0000.
- R5: A write leaves every bit outside the addressed segment unchanged.
- R6: A read is accepted under the same conditions as a write. `rd_valid` drops on the accepting edge. It rises 1+d+SEG_W edges after that edge, with d as in R3, and `rd_data` then holds the stored word.
- R7: `rd_data` and `rd_valid` stay static until the next read is accepted. A read does not change the stored data.
- R8: `busy` is high from the accepting edge until the access completes. A request made while `busy` is high is ignored.
- R9: If `wr_req` and `rd_req` are both high in the same idle cycle, the write is performed and the read is dropped.
- R10: Stored words survive any number of trips around the ring while no write targets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Write request, sampled while idle |
| wr_seg | input | SEG_IW | Segment to write |
| wr_data | input | SEG_W | Word to write, bit 0 first |
| wr_ack | output | 1 | One-cycle pulse after the last bit is replaced |
| rd_req | input | 1 | Read request, sampled while idle |
| rd_seg | input | SEG_IW | Segment to read |
| rd_data | output | SEG_W | Captured word |
| rd_valid | output | 1 | High while rd_data holds a completed read |
| busy | output | 1 | An access is pending; requests ignored |

## Verification
A position counter that slips out of phase with the ring shows up at the ports in two ways. The acknowledge or valid arrives on the wrong edge relative to the R3 formula, and read-back words come out rotated or taken from a neighbouring segment. Both appear on the first access after the fault. An erase window that is one bit early or late corrupts a neighbouring segment. That damage becomes visible on the next read of that neighbour, within one revolution of L cycles. A capture strobe with the wrong bit alignment shows up immediately as a wrong `rd_data` on the same read.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } sdm_state_e;

  // index width for a count of n items, never zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // total ring length in bit positions
  function automatic int ring_len(input int seg_w, input int seg_n);
    return seg_w * seg_n;
  endfunction

endpackage

// File: rtl/sdm_pos_counter.sv
module sdm_pos_counter
  import sdm_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int BIT_IW = idx_w(SEG_W),
  localparam int SEG_IW = idx_w(SEG_N),
  localparam int POS_W  = idx_w(ring_len(SEG_W, SEG_N))
) (
  input  logic              clk,
  input  logic              rst,
  output logic [BIT_IW-1:0] bit_idx,
  output logic [SEG_IW-1:0] seg_idx,
  output logic [POS_W-1:0]  pos
);

  logic [BIT_IW-1:0] bit_q;
  logic [SEG_IW-1:0] seg_q;
  logic              bit_wrap;
  logic              seg_wrap;

  assign bit_wrap = (bit_q == BIT_IW'(SEG_W - 1));
  assign seg_wrap = (seg_q == SEG_IW'(SEG_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      seg_q <= '0;
    end else if (bit_wrap) begin
      bit_q <= '0;
      seg_q <= seg_wrap ? '0 : seg_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign bit_idx = bit_q;
  assign seg_idx = seg_q;
  assign pos     = POS_W'(seg_q) * POS_W'(SEG_W) + POS_W'(bit_q);

endmodule

// File: rtl/sdm_ring.sv
module sdm_ring #(
  parameter int LOOP_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic put_en,
  input  logic put_bit,
  output logic tap
);

  logic [LOOP_LEN-1:0] ring_q;
  logic                feed;

  // the bit leaving the access point re-enters the far end,
  // unless the current access substitutes a new value for it
  assign feed = put_en ? put_bit : ring_q[0];
  assign tap  = ring_q[0];

  generate
    if (LOOP_LEN > 1) begin : g_long
      always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= {feed, ring_q[LOOP_LEN-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= feed;
      end
    end
  endgenerate

endmodule

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int BIT_IW = idx_w(SEG_W),
  localparam int SEG_IW = idx_w(SEG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [SEG_IW-1:0] wr_seg,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              rd_req,
  input  logic [SEG_IW-1:0] rd_seg,
  input  logic [BIT_IW-1:0] bit_idx,
  input  logic [SEG_IW-1:0] seg_idx,
  output logic              busy,
  output logic              wr_ack,
  output logic              strobe,
  output logic              last_bit,
  output logic              is_wr,
  output logic [SEG_IW-1:0] tgt_seg,
  output logic              put_en,
  output logic              put_bit,
  output logic              rd_start
);

  sdm_state_e        st_q;
  logic              op_wr_q;
  logic [SEG_IW-1:0] tgt_q;
  logic [SEG_W-1:0]  data_q;
  logic              at_base;

  // segment start is in phase with the access point
  assign at_base  = (seg_idx == tgt_q) && (bit_idx == '0);
  assign strobe   = ((st_q == ST_WAIT) && at_base) || (st_q == ST_XFER);
  assign last_bit = strobe && (bit_idx == BIT_IW'(SEG_W - 1));
  assign put_en   = strobe && op_wr_q;
  assign put_bit  = data_q[bit_idx];
  assign busy     = (st_q != ST_IDLE);
  assign wr_ack   = (st_q == ST_DONE) && op_wr_q;
  assign rd_start = (st_q == ST_IDLE) && !wr_req && rd_req;
  assign is_wr    = op_wr_q;
  assign tgt_seg  = tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_wr_q <= 1'b0;
      tgt_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_req) begin
            op_wr_q <= 1'b1;
            tgt_q   <= wr_seg;
            data_q  <= wr_data;
            st_q    <= ST_WAIT;
          end else if (rd_req) begin
            op_wr_q <= 1'b0;
            tgt_q   <= rd_seg;
            st_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (last_bit)    st_q <= ST_DONE;
          else if (strobe) st_q <= ST_XFER;
        end
        ST_XFER: begin
          if (last_bit) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdm_capture.sv
module sdm_capture
  import sdm_pkg::*;
#(
  parameter int SEG_W = 4,
  localparam int BIT_IW = idx_w(SEG_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic [BIT_IW-1:0] bit_idx,
  input  logic              tap,
  output logic [SEG_W-1:0]  rd_data,
  output logic              rd_valid
);

  // one latch per word bit, each opened only when its own delayed
  // strobe coincides with the passing ring bit
  generate
    for (genvar i = 0; i < SEG_W; i++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst)                                   rd_data[i] <= 1'b0;
        else if (cap_en && bit_idx == BIT_IW'(i))  rd_data[i] <= tap;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           rd_valid <= 1'b0;
    else if (clr)      rd_valid <= 1'b0;
    else if (cap_last) rd_valid <= 1'b1;
  end

endmodule

// File: rtl/seg_delay_mem.sv
module seg_delay_mem
  import sdm_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int SEG_IW = idx_w(SEG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [SEG_IW-1:0] wr_seg,
  input  logic [SEG_W-1:0]  wr_data,
  output logic              wr_ack,
  input  logic              rd_req,
  input  logic [SEG_IW-1:0] rd_seg,
  output logic [SEG_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              busy
);

  localparam int LOOP_LEN = ring_len(SEG_W, SEG_N);
  localparam int BIT_IW   = idx_w(SEG_W);
  localparam int POS_W    = idx_w(LOOP_LEN);

  logic [BIT_IW-1:0] bit_idx;
  logic [SEG_IW-1:0] seg_idx;
  logic [POS_W-1:0]  pos;
  logic              tap;
  logic              put_en;
  logic              put_bit;
  logic              strobe;
  logic              last_bit;
  logic              is_wr;
  logic [SEG_IW-1:0] tgt_seg;
  logic              rd_start;
  logic              cap_en;
  logic              cap_last;

  assign cap_en   = strobe && !is_wr;
  assign cap_last = last_bit && !is_wr;

  sdm_pos_counter #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .bit_idx (bit_idx),
    .seg_idx (seg_idx),
    .pos     (pos)
  );

  sdm_ring #(.LOOP_LEN(LOOP_LEN)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .put_en  (put_en),
    .put_bit (put_bit),
    .tap     (tap)
  );

  sdm_ctrl #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .wr_seg   (wr_seg),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_seg   (rd_seg),
    .bit_idx  (bit_idx),
    .seg_idx  (seg_idx),
    .busy     (busy),
    .wr_ack   (wr_ack),
    .strobe   (strobe),
    .last_bit (last_bit),
    .is_wr    (is_wr),
    .tgt_seg  (tgt_seg),
    .put_en   (put_en),
    .put_bit  (put_bit),
    .rd_start (rd_start)
  );

  sdm_capture #(.SEG_W(SEG_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clr      (rd_start),
    .cap_en   (cap_en),
    .cap_last (cap_last),
    .bit_idx  (bit_idx),
    .tap      (tap),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker
  import sdm_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4,
  localparam int SEG_IW = idx_w(SEG_N),
  localparam int POS_W  = idx_w(ring_len(SEG_W, SEG_N))
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wr_ack,
  input logic              rd_valid,
  input logic [SEG_W-1:0]  rd_data,
  input logic [POS_W-1:0]  pos,
  input logic [SEG_IW-1:0] seg_idx,
  input logic [SEG_IW-1:0] tgt_seg,
  input logic              strobe,
  input logic              last_bit,
  input logic              is_wr
);

  localparam int LEN = ring_len(SEG_W, SEG_N);

  function automatic logic [POS_W-1:0] step(input logic [POS_W-1:0] p);
    return (p == POS_W'(LEN - 1)) ? '0 : p + 1'b1;
  endfunction

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !wr_ack && !rd_valid && rd_data == '0));

  assert_pos_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pos == step($past(pos))));

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  assert_ack_follows_last_R3: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(last_bit && is_wr));

  assert_strobe_in_segment_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (seg_idx == tgt_seg));

  assert_valid_follows_last_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(last_bit && !is_wr));

  assert_data_static_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_data));

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_ack && $rose(rd_valid)));

endmodule

bind seg_delay_mem sdm_checker #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .wr_ack   (wr_ack),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .pos      (pos),
  .seg_idx  (seg_idx),
  .tgt_seg  (tgt_seg),
  .strobe   (strobe),
  .last_bit (last_bit),
  .is_wr    (is_wr)
);

// File: tb/seg_delay_mem_bench.sv
module seg_delay_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int N  = 4;
  localparam int L  = W * N;
  localparam int SIW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_req = 1'b0;
  logic [SIW-1:0] wr_seg = '0;
  logic [W-1:0]   wr_data = '0;
  logic           wr_ack;
  logic           rd_req = 1'b0;
  logic [SIW-1:0] rd_seg = '0;
  logic [W-1:0]   rd_data;
  logic           rd_valid;
  logic           busy;

  int nvec = 0;
  int nfail = 0;
  int tick = 0;
  int ack_count = 0;
  logic [W-1:0] shadow [N];

  seg_delay_mem #(.SEG_W(W), .SEG_N(N)) u_seg_delay_mem (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_seg(wr_seg), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_seg(rd_seg), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tick <= rst ? 0 : tick + 1;
    if (!rst && wr_ack) ack_count <= ack_count + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  function automatic int expect_edges(input int seg, input int p);
    int d;
    d = ((seg * W - p - 1) % L + L) % L;
    return 1 + d + W;
  endfunction

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 4 * L) begin
      @(negedge clk);
      guard++;
    end
    check(!busy, "R8", "busy never released", int'(busy), 0);
  endtask

  task automatic wait_pos(input int target);
    for (int g = 0; g < L && (tick % L) != target; g++) @(negedge clk);
  endtask

  task automatic do_write(input int seg, input logic [W-1:0] data, input string req,
                          input int at_pos = -1);
    int p, n, guard;
    wait_idle();
    if (at_pos >= 0) wait_pos(at_pos);
    p = tick % L;
    wr_req = 1'b1; wr_seg = SIW'(seg); wr_data = data;
    @(negedge clk);
    wr_req = 1'b0;
    n = 1; guard = 0;
    check(busy, "R8", "busy after write accept", int'(busy), 1);
    while (!wr_ack && guard < 4 * L) begin
      @(negedge clk); n++; guard++;
    end
    check(n == expect_edges(seg, p), req, "write ack latency R3", n, expect_edges(seg, p));
    @(negedge clk);
    check(!wr_ack, "R3", "ack longer than one cycle", int'(wr_ack), 0);
    shadow[seg] = data;
  endtask

  task automatic do_read(input int seg, input string req, input int at_pos = -1);
    int p, n, guard;
    wait_idle();
    if (at_pos >= 0) wait_pos(at_pos);
    p = tick % L;
    rd_req = 1'b1; rd_seg = SIW'(seg);
    @(negedge clk);
    rd_req = 1'b0;
    n = 1; guard = 0;
    check(!rd_valid, "R6", "valid not cleared on accept", int'(rd_valid), 0);
    while (!rd_valid && guard < 4 * L) begin
      @(negedge clk); n++; guard++;
    end
    check(n == expect_edges(seg, p), req, "read latency R6", n, expect_edges(seg, p));
    check(rd_data == shadow[seg], req, "read data", int'(rd_data), int'(shadow[seg]));
  endtask

  task automatic t_reset();
    check(!busy && !wr_ack && !rd_valid, "R1", "status after reset",
          {busy, wr_ack, rd_valid}, 0);
    check(rd_data == '0, "R1", "rd_data after reset", int'(rd_data), 0);
    for (int s = 0; s < N; s++) do_read(s, "R1");
  endtask

  task automatic t_basic();
    do_write(0, 4'h5, "R3"); do_write(1, 4'hC, "R3");
    do_write(2, 4'h9, "R3"); do_write(3, 4'h3, "R3");
    for (int s = N - 1; s >= 0; s--) do_read(s, "R6");
  endtask

  task automatic t_erase();
    for (int s = 0; s < N; s++) do_write(s, 4'hF, "R4");
    do_write(1, 4'h0, "R4");
    do_read(1, "R4");
    do_read(0, "R5"); do_read(2, "R5");
    do_write(2, 4'h6, "R4");
    do_read(1, "R5"); do_read(3, "R5"); do_read(2, "R4");
  endtask

  task automatic t_phase();
    do_write(2, 4'hA, "R2", 2 * W - 1);
    do_write(1, 4'h7, "R2", W);
    do_read(2, "R2", 2 * W);
    do_read(1, "R2", W - 1);
    do_read(0, "R2", L - 1);
  endtask

  task automatic t_busy_ignore();
    int acks;
    logic [W-1:0] held;
    wait_idle();
    acks = ack_count;
    rd_req = 1'b1; rd_seg = 2'd2;
    @(negedge clk);
    rd_req = 1'b0;
    wr_req = 1'b1; wr_seg = 2'd2; wr_data = ~shadow[2];
    rd_seg = 2'd3;
    check(busy, "R8", "busy during pending read", int'(busy), 1);
    @(negedge clk);
    wr_req = 1'b0;
    for (int g = 0; g < 4 * L && !rd_valid; g++) @(negedge clk);
    check(rd_data == shadow[2], "R8", "read result", int'(rd_data), int'(shadow[2]));
    held = rd_data;
    check(ack_count == acks, "R8", "write taken while busy", ack_count, acks);
    do_read(2, "R8");
    check(held == rd_data, "R7", "read altered data", int'(rd_data), int'(held));
  endtask

  task automatic t_collide();
    logic [W-1:0] old;
    do_read(0, "R9");
    old = rd_data;
    wait_idle();
    wr_req = 1'b1; wr_seg = 2'd3; wr_data = 4'hB;
    rd_req = 1'b1; rd_seg = 2'd1;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    for (int g = 0; g < 4 * L && !wr_ack; g++) @(negedge clk);
    check(wr_ack, "R9", "write not performed", int'(wr_ack), 1);
    check(rd_valid && rd_data == old, "R9", "read not dropped", int'(rd_data), int'(old));
    @(negedge clk);
    check(!busy, "R9", "read queued", int'(busy), 0);
    shadow[3] = 4'hB;
    do_read(3, "R9");
  endtask

  task automatic t_hold_and_persist();
    logic [W-1:0] held;
    do_read(1, "R7");
    held = rd_data;
    for (int k = 0; k < 3; k++) begin
      repeat (L + 3) @(negedge clk);
      check(rd_valid && rd_data == held, "R7", "output not static",
            int'(rd_data), int'(held));
    end
    repeat (5 * L) @(negedge clk);
    for (int s = 0; s < N; s++) do_read(s, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) shadow[s] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_erase();
    t_phase();
    t_busy_ignore();
    t_collide();
    t_hold_and_persist();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule